// File: doc/BRIEF.md
# Bus Error Reporting Controller

This block collects error events seen by a host bridge and turns them into the bridge's error signals. It holds an 8-bit error command register. Each bit of that register enables one kind of report. The bits sit under two gate inputs that come from the bridge's separate PCI command register: a parity-response enable and a system-error enable. Six single-cycle event strobes come in:

- a target abort received;
- a data parity error on an outbound write;
- a data parity error on returned read data;
- an address parity error;
- a data parity error on an inbound master write to memory;
- a parity-check strobe from the processor during memory or L2 cache reads.

The block drives the active-low SERR and PERR lines and a parity-enable level to the processor. It also keeps a set of sticky status bits.

Each of SERR and PERR comes from a two-state machine with the states `SIG_IDLE` and `SIG_DRIVE`. The machine takes the transition IDLE→DRIVE when a qualified request arrives. It takes DRIVE→DRIVE when another request arrives in the next cycle. It takes DRIVE→IDLE when no request is present, and it stays in IDLE otherwise. The pin is low exactly while the machine is in `SIG_DRIVE`.

The L2 parity master enable masks the two memory-parity controls. The encoding 2'b10 of those two controls is reserved. The block treats it as both controls off and flags it.

Top module: `bus_err_reporter`

## Requirements
- R1: After reset the command register reads 8'h00, serr_n and perr_n are 1, err_status is 0, cpu_pen is 0 and config_error is 0.
- R2: A cycle with cfg_wr_en high loads cfg_wr_data into the command register, and cfg_rd_data shows the new value from the next cycle. An event in the write cycle is judged against the old value.
- R3: ev_tgt_abort with command bit 7 and pci_serr_en set requests SERR and sets err_status[0].
- R4: ev_wr_dperr with command bit 6 and both gates set requests SERR and sets err_status[1].
- R5: ev_rd_dperr with command bit 5 and both gates set requests SERR and sets err_status[2].
- R6: ev_addr_perr with command bit 4 and both gates set requests SERR and sets err_status[3].
- R7: ev_rd_dperr or ev_mst_wr_dperr with command bit 3 and pci_perr_resp_en set drives perr_n low for one clock, starting in the cycle after the event, and sets err_status[4]. pci_serr_en plays no part in this.
- R8: When command bit 2 is 0, ev_pchk has no effect and cpu_pen is 0, whatever bits 1:0 hold.
- R9: With bit 2 set and bits 1:0 = 2'b01, cpu_pen is 1. ev_pchk then sets err_status[5] and does not request SERR.
- R10: With bit 2 set, bits 1:0 = 2'b11 and both gates set, ev_pchk sets err_status[5] and requests SERR.
- R11: Bits 1:0 = 2'b10 raise config_error and act as both controls off: cpu_pen is 0 and ev_pchk has no effect.
- R12: serr_n is low in the cycle after every cycle that holds at least one SERR request. It is high after a cycle with none, so consecutive request cycles keep it low for the same number of cycles.
- R13: err_status bits are sticky. Each is cleared by a 1 on the matching sts_clr bit, and a new set wins over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Write strobe for the command register |
| cfg_wr_data | input | 8 | Command register write value |
| cfg_rd_data | output | 8 | Command register contents |
| config_error | output | 1 | Reserved 2'b10 encoding in bits 1:0 |
| pci_perr_resp_en | input | 1 | Parity-response gate from the PCI command register |
| pci_serr_en | input | 1 | System-error gate from the PCI command register |
| ev_tgt_abort | input | 1 | Target abort received strobe |
| ev_wr_dperr | input | 1 | Outbound write data parity error strobe |
| ev_rd_dperr | input | 1 | Read return data parity error strobe |
| ev_addr_perr | input | 1 | Address parity error strobe |
| ev_mst_wr_dperr | input | 1 | Inbound master write data parity error strobe |
| ev_pchk | input | 1 | Processor parity-check strobe on memory or L2 reads |
| sts_clr | input | 6 | Write-1-to-clear for err_status |
| err_status | output | 6 | Sticky status: 0 abort, 1 write, 2 read, 3 address, 4 PERR, 5 L2/memory |
| serr_n | output | 1 | System error, active low |
| perr_n | output | 1 | Parity error, active low |
| cpu_pen | output | 1 | Parity-enable level to the processor |

## Verification
A wrong machine state shows up on serr_n or perr_n in the very next cycle. A machine stuck in `SIG_DRIVE` stretches the pulse. One that fails to leave `SIG_IDLE` drops it. A corrupted command bit shows on cfg_rd_data and cpu_pen at once, and in the one cycle after the next matching strobe. A lost or spurious status bit stays visible on err_status until it is cleared. The bench therefore checks every output on every clock against a behavioural model, including the cycles where a write and an event meet.

// File: rtl/ber_pkg.sv
package ber_pkg;

    localparam int CMD_W   = 8;
    localparam int NUM_SRC = 6;

    // status bit positions
    localparam int ST_ABORT = 0;
    localparam int ST_WRPAR = 1;
    localparam int ST_RDPAR = 2;
    localparam int ST_ADPAR = 3;
    localparam int ST_PERR  = 4;
    localparam int ST_L2PAR = 5;

    typedef enum logic {
        SIG_IDLE  = 1'b0,
        SIG_DRIVE = 1'b1
    } sig_state_e;

    typedef struct packed {
        logic abort_serr;   // bit 7
        logic wr_par_serr;  // bit 6
        logic rd_par_serr;  // bit 5
        logic ad_par_serr;  // bit 4
        logic perr_drive;   // bit 3
        logic l2_par_en;    // bit 2
        logic l2_serr;      // bit 1
        logic l2_chk;       // bit 0
    } err_cmd_t;

endpackage

// File: rtl/ber_cmd_reg.sv
module ber_cmd_reg
    import ber_pkg::*;
#(
    parameter bit HAS_EXT_SOURCES = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CMD_W-1:0] wr_data,
    output err_cmd_t         cmd,
    output logic [CMD_W-1:0] rd_data,
    output logic             cfg_err,
    output logic             l2_chk_on,
    output logic             l2_serr_on
);

    localparam logic [CMD_W-1:0] FULL_MASK = {CMD_W{1'b1}};
    localparam logic [CMD_W-1:0] EXT_BITS  = 8'h38;

    logic [CMD_W-1:0] wmask;
    logic [CMD_W-1:0] cmd_q;

    generate
        if (HAS_EXT_SOURCES) begin : g_full
            assign wmask = FULL_MASK;
        end else begin : g_basic
            assign wmask = FULL_MASK & ~EXT_BITS;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (wr_en) begin
            cmd_q <= wr_data & wmask;
        end
    end

    always_comb begin
        cmd        = err_cmd_t'(cmd_q);
        rd_data    = cmd_q;
        cfg_err    = (cmd_q[1:0] == 2'b10);
        l2_chk_on  = cmd.l2_par_en && cmd.l2_chk;
        l2_serr_on = cmd.l2_par_en && cmd.l2_chk && cmd.l2_serr;
    end

endmodule

// File: rtl/ber_qualify.sv
module ber_qualify
    import ber_pkg::*;
(
    input  err_cmd_t             cmd,
    input  logic                 perr_en,
    input  logic                 serr_en,
    input  logic                 l2_chk_on,
    input  logic                 l2_serr_on,
    input  logic                 ev_abort,
    input  logic                 ev_wr,
    input  logic                 ev_rd,
    input  logic                 ev_ad,
    input  logic                 ev_mw,
    input  logic                 ev_pchk,
    output logic                 serr_req,
    output logic                 perr_req,
    output logic [NUM_SRC-1:0]   sts_set
);

    logic both_gates;
    logic l2_hit;

    always_comb begin
        both_gates = perr_en && serr_en;
        l2_hit     = ev_pchk && l2_chk_on;

        sts_set           = '0;
        sts_set[ST_ABORT] = ev_abort && cmd.abort_serr && serr_en;
        sts_set[ST_WRPAR] = ev_wr && cmd.wr_par_serr && both_gates;
        sts_set[ST_RDPAR] = ev_rd && cmd.rd_par_serr && both_gates;
        sts_set[ST_ADPAR] = ev_ad && cmd.ad_par_serr && both_gates;
        sts_set[ST_PERR]  = (ev_rd || ev_mw) && cmd.perr_drive && perr_en;
        sts_set[ST_L2PAR] = l2_hit;

        perr_req = sts_set[ST_PERR];
        serr_req = sts_set[ST_ABORT] || sts_set[ST_WRPAR]
                || sts_set[ST_RDPAR] || sts_set[ST_ADPAR]
                || (l2_hit && l2_serr_on && both_gates);
    end

endmodule

// File: rtl/ber_pulse_fsm.sv
module ber_pulse_fsm
    import ber_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic sig_n
);

    sig_state_e state_q;
    sig_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SIG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SIG_IDLE:  if (req)  state_d = SIG_DRIVE;
            SIG_DRIVE: if (!req) state_d = SIG_IDLE;
            default:   state_d = SIG_IDLE;
        endcase
    end

    always_comb begin
        sig_n = 1'b1;
        unique case (state_q)
            SIG_IDLE:  sig_n = 1'b1;
            SIG_DRIVE: sig_n = 1'b0;
            default:   sig_n = 1'b1;
        endcase
    end

endmodule

// File: rtl/ber_status.sv
module ber_status
    import ber_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] sts
);

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sts[i] <= 1'b0;
                end else if (set[i]) begin
                    sts[i] <= 1'b1;
                end else if (clr[i]) begin
                    sts[i] <= 1'b0;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/bus_err_reporter.sv
module bus_err_reporter
    import ber_pkg::*;
#(
    parameter bit HAS_EXT_SOURCES = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr_en,
    input  logic [CMD_W-1:0]   cfg_wr_data,
    output logic [CMD_W-1:0]   cfg_rd_data,
    output logic               config_error,
    input  logic               pci_perr_resp_en,
    input  logic               pci_serr_en,
    input  logic               ev_tgt_abort,
    input  logic               ev_wr_dperr,
    input  logic               ev_rd_dperr,
    input  logic               ev_addr_perr,
    input  logic               ev_mst_wr_dperr,
    input  logic               ev_pchk,
    input  logic [NUM_SRC-1:0] sts_clr,
    output logic [NUM_SRC-1:0] err_status,
    output logic               serr_n,
    output logic               perr_n,
    output logic               cpu_pen
);

    localparam int NUM_PINS = 2;

    err_cmd_t              cmd;
    logic                  l2_chk_on;
    logic                  l2_serr_on;
    logic                  serr_req;
    logic                  perr_req;
    logic [NUM_SRC-1:0]    sts_set;
    logic [NUM_PINS-1:0]   pin_req;
    logic [NUM_PINS-1:0]   pin_n;

    ber_cmd_reg #(
        .HAS_EXT_SOURCES (HAS_EXT_SOURCES)
    ) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_wr_en),
        .wr_data    (cfg_wr_data),
        .cmd        (cmd),
        .rd_data    (cfg_rd_data),
        .cfg_err    (config_error),
        .l2_chk_on  (l2_chk_on),
        .l2_serr_on (l2_serr_on)
    );

    ber_qualify u_qual (
        .cmd        (cmd),
        .perr_en    (pci_perr_resp_en),
        .serr_en    (pci_serr_en),
        .l2_chk_on  (l2_chk_on),
        .l2_serr_on (l2_serr_on),
        .ev_abort   (ev_tgt_abort),
        .ev_wr      (ev_wr_dperr),
        .ev_rd      (ev_rd_dperr),
        .ev_ad      (ev_addr_perr),
        .ev_mw      (ev_mst_wr_dperr),
        .ev_pchk    (ev_pchk),
        .serr_req   (serr_req),
        .perr_req   (perr_req),
        .sts_set    (sts_set)
    );

    ber_status #(
        .N (NUM_SRC)
    ) u_sts (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (sts_set),
        .clr   (sts_clr),
        .sts   (err_status)
    );

    assign pin_req = {perr_req, serr_req};

    genvar p;
    generate
        for (p = 0; p < NUM_PINS; p++) begin : g_pin
            ber_pulse_fsm u_fsm (
                .clk   (clk),
                .rst_n (rst_n),
                .req   (pin_req[p]),
                .sig_n (pin_n[p])
            );
        end
    endgenerate

    assign serr_n  = pin_n[0];
    assign perr_n  = pin_n[1];
    assign cpu_pen = l2_chk_on;

endmodule

// File: rtl/ber_chk.sv
module ber_chk
    import ber_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               serr_req,
    input logic               perr_req,
    input logic               serr_n,
    input logic               perr_n,
    input logic [NUM_SRC-1:0] err_status,
    input logic [NUM_SRC-1:0] sts_clr,
    input logic               config_error,
    input logic               cpu_pen,
    input logic [CMD_W-1:0]   cfg_rd_data
);

    // R12
    serr_assert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        serr_req |=> !serr_n);

    // R12
    serr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_req |=> serr_n);

    // R7
    perr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        perr_req |=> !perr_n);

    // R7
    perr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_req |=> perr_n);

    // R13
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(err_status) & ~$past(sts_clr)) & ~err_status) == '0));

    // R11
    reserved_pen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        config_error |-> !cpu_pen);

    // R8
    l2_off_pen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rd_data[2] |-> !cpu_pen);

endmodule

bind bus_err_reporter ber_chk u_ber_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .serr_req     (serr_req),
    .perr_req     (perr_req),
    .serr_n       (serr_n),
    .perr_n       (perr_n),
    .err_status   (err_status),
    .sts_clr      (sts_clr),
    .config_error (config_error),
    .cpu_pen      (cpu_pen),
    .cfg_rd_data  (cfg_rd_data)
);

// File: tb/bus_err_reporter_test.sv
module bus_err_reporter_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr_en = 1'b0;
    logic [7:0] cfg_wr_data = 8'h00;
    logic [7:0] cfg_rd_data;
    logic       config_error;
    logic       pci_perr_resp_en = 1'b0;
    logic       pci_serr_en = 1'b0;
    logic [5:0] ev = 6'h00;   // {pchk, mst_wr, addr, rd, wr, abort}
    logic [5:0] sts_clr = 6'h00;
    logic [5:0] err_status;
    logic       serr_n;
    logic       perr_n;
    logic       cpu_pen;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit ready = 1'b0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    bus_err_reporter uut (
        .clk              (clk),
        .rst_n            (rst_n),
        .cfg_wr_en        (cfg_wr_en),
        .cfg_wr_data      (cfg_wr_data),
        .cfg_rd_data      (cfg_rd_data),
        .config_error     (config_error),
        .pci_perr_resp_en (pci_perr_resp_en),
        .pci_serr_en      (pci_serr_en),
        .ev_tgt_abort     (ev[0]),
        .ev_wr_dperr      (ev[1]),
        .ev_rd_dperr      (ev[2]),
        .ev_addr_perr     (ev[3]),
        .ev_mst_wr_dperr  (ev[4]),
        .ev_pchk          (ev[5]),
        .sts_clr          (sts_clr),
        .err_status       (err_status),
        .serr_n           (serr_n),
        .perr_n           (perr_n),
        .cpu_pen          (cpu_pen)
    );

    // behavioural reference model
    bit [7:0] m_cmd = 8'h00;
    bit [5:0] m_sts = 6'h00;
    bit       m_serr_n = 1'b1;
    bit       m_perr_n = 1'b1;

    always @(posedge clk) begin
        bit s;
        bit p;
        bit g2;
        bit [5:0] set;
        if (!rst_n) begin
            m_cmd = 8'h00; m_sts = 6'h00; m_serr_n = 1'b1; m_perr_n = 1'b1;
        end else begin
            g2 = pci_perr_resp_en && pci_serr_en;
            set = 6'h00;
            s = 1'b0;
            p = 1'b0;
            if (ev[0] && m_cmd[7] && pci_serr_en) set[0] = 1'b1;   // R3
            if (ev[1] && m_cmd[6] && g2) set[1] = 1'b1;            // R4
            if (ev[2] && m_cmd[5] && g2) set[2] = 1'b1;            // R5
            if (ev[3] && m_cmd[4] && g2) set[3] = 1'b1;            // R6
            if ((ev[2] || ev[4]) && m_cmd[3] && pci_perr_resp_en) begin
                set[4] = 1'b1; p = 1'b1;                           // R7
            end
            if (ev[5] && m_cmd[2] && m_cmd[0]) begin               // R9
                set[5] = 1'b1;
                if (m_cmd[1] && g2) s = 1'b1;                      // R10
            end
            if (set[3:0] != 4'h0) s = 1'b1;
            m_serr_n = !s;
            m_perr_n = !p;
            m_sts = (m_sts & ~sts_clr) | set;                      // R13
            if (cfg_wr_en) m_cmd = cfg_wr_data;                    // R2
        end
        ready = 1'b1;
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d",
                     req, what, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        if (ready && !finished) begin
            check("R12", "serr_n", serr_n, m_serr_n);
            check("R7", "perr_n", perr_n, m_perr_n);
            check("R13", "err_status", err_status, m_sts);
            check("R2", "cfg_rd_data", cfg_rd_data, m_cmd);
            check("R9", "cpu_pen", cpu_pen, m_cmd[2] && m_cmd[0]);
            check("R11", "config_error", config_error, m_cmd[1:0] == 2'b10);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            mismatched++;
            $display("FAIL watchdog expired actual=%0d expected=done", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_cmd(input logic [7:0] v);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_data = v;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic strobe(input logic [5:0] e);
        @(negedge clk);
        ev = e;
        @(negedge clk);
        ev = 6'h00;
    endtask

    task automatic clear_all();
        @(negedge clk);
        sts_clr = 6'h3F;
        @(negedge clk);
        sts_clr = 6'h00;
    endtask

    initial begin
        wait_cyc(3);
        // R1: reset values held during reset
        check("R1", "reset serr_n", serr_n, 1'b1);
        check("R1", "reset cfg_rd_data", cfg_rd_data, 8'h00);
        check("R1", "reset err_status", err_status, 6'h00);
        check("R1", "reset cpu_pen", cpu_pen, 1'b0);
        rst_n = 1'b1;
        wait_cyc(2);

        // R3: abort needs only the system-error gate
        wr_cmd(8'h80);
        pci_serr_en = 1'b1;
        strobe(6'h01);
        wait_cyc(1);
        pci_serr_en = 1'b0;
        strobe(6'h01);                      // gate off: no effect
        clear_all();

        // R4 R5 R6: both gates required
        wr_cmd(8'h70);
        pci_serr_en = 1'b1;
        strobe(6'h0E);                      // parity gate off: nothing
        pci_perr_resp_en = 1'b1;
        strobe(6'h02);
        strobe(6'h04);
        strobe(6'h08);
        // R12: back-to-back and coincident requests
        @(negedge clk); ev = 6'h02;
        @(negedge clk); ev = 6'h0C;
        @(negedge clk); ev = 6'h00;
        wait_cyc(2);
        clear_all();

        // R7: PERR from read or master write, SERR gate irrelevant
        wr_cmd(8'h08);
        pci_serr_en = 1'b0;
        strobe(6'h04);
        strobe(6'h10);
        pci_perr_resp_en = 1'b0;
        strobe(6'h10);                      // gate off
        pci_perr_resp_en = 1'b1;
        pci_serr_en = 1'b1;

        // R8: L2 master off ignores pchk
        wr_cmd(8'h03);
        strobe(6'h20);
        // R9: check-only mode
        wr_cmd(8'h05);
        strobe(6'h20);
        clear_all();
        // R10: full L2 reporting
        wr_cmd(8'h07);
        strobe(6'h20);
        pci_serr_en = 1'b0;
        strobe(6'h20);                      // status only
        pci_serr_en = 1'b1;
        // R11: reserved encoding
        wr_cmd(8'h06);
        strobe(6'h20);
        clear_all();

        // R13: set beats clear in the same cycle; clear alone works
        wr_cmd(8'h80);
        @(negedge clk); ev = 6'h01; sts_clr = 6'h01;
        @(negedge clk); ev = 6'h00; sts_clr = 6'h00;
        wait_cyc(1);
        @(negedge clk); sts_clr = 6'h01;
        @(negedge clk); sts_clr = 6'h00;

        // R2: write and event in the same cycle uses the old value
        @(negedge clk); cfg_wr_en = 1'b1; cfg_wr_data = 8'h00; ev = 6'h01;
        @(negedge clk); cfg_wr_en = 1'b0; ev = 6'h00;
        strobe(6'h01);

        // mixed traffic across all outputs
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            ev = 6'($urandom) & 6'($urandom);
            sts_clr = ($urandom % 8 == 0) ? 6'($urandom) : 6'h00;
            pci_perr_resp_en = ($urandom % 4) != 0;
            pci_serr_en = ($urandom % 4) != 0;
            cfg_wr_en = ($urandom % 16) == 0;
            cfg_wr_data = 8'($urandom);
        end
        @(negedge clk);
        ev = 6'h00; sts_clr = 6'h00; cfg_wr_en = 1'b0;
        wait_cyc(3);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule